// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames, delivered one byte per cycle with end-of-frame error flags, and stores each one in a host-supplied buffer named by the current entry of a descriptor ring. A ring entry occupies eight 16-bit words (16 bytes, 16-byte aligned):

| Word | Meaning |
|------|---------|
| 0, 1 | Buffer byte address, low half then high half |
| 2 | Buffer size, held as its two's-complement negative |
| 3 | Status word |
| 4, 5 | Message length, low word then high word |
| 6, 7 | Reserved |

Bit 15 of the status word is the hand-off flag. When it is 1, the block may fill the entry. After a frame is stored, the block writes the length and the status, and clears the flag last. The host sets the flag again to give the entry back.

The descriptor table and the buffers share one internal 16-bit memory. The host reaches this memory through a simple word port. Byte address `a` maps to word `a>>1`; an even byte goes in bits 7:0 and an odd byte in bits 15:8. The ring starts at `ring_base`, and its size is 2^k entries. The value k is read from bits 7:4 of `ring_len_cfg` and is limited to `MAX_LOG`. After the last entry, the index returns to 0.

Each frame must fit in a single buffer. The block does not implement the line side.

Top module: `rxr_desc_writer`

## Requirements
- R1: After reset, `missed_cnt` and `host_rdata` are 0, and the first frame is placed through ring entry 0.
- R2: Frame byte n is written to buffer byte address base+n, in little-endian byte lanes. Buffer bytes past the stored count are left unchanged.
- R3: Word 4 of the entry gets the number of stored bytes in bits 11:0, with bits 15:12 zero. Word 5 is written to zero.
- R4: For a frame with no errors, the status word is written as 0x03 in bits 15:8 (bit 9 start-of-frame, bit 8 end-of-frame), with bit 15 clear. Bits 7:0 keep the host's value.
- R5: Error flags map into the status word as follows: framing to bit 13, CRC to bit 11, buffer/FIFO to bit 10. Bit 14 is set whenever any error bit is set, and bits 9:8 stay set.
- R6: If a frame is longer than the buffer size (the negated word 2), only the first size bytes are stored, word 4 holds the buffer size, and bit 12 (overflow) is set.
- R7: The ring index advances by one after each stored frame and wraps at 2^k. The value k comes from `ring_len_cfg[7:4]`, is clamped to `MAX_LOG`, and all other bits of `ring_len_cfg` are ignored.
- R8: A frame arriving while the current entry has bit 15 clear is discarded. `missed_cnt` increases by 1, the entry and its buffer stay unchanged, and the index does not move.
- R9: Bit 15 of the status word is cleared by a write that comes after words 4 and 5 are written and after the final status bits are already present, with bit 15 still set, in the previous cycle.
- R10: A frame whose first byte arrives during the four write-back cycles after a frame's last byte is discarded and counted in `missed_cnt`.
- R11: A host write takes effect at the next clock edge. A host read returns the addressed word one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW+1 | Byte address of ring entry 0 (bits 3:0 ignored) |
| ring_len_cfg | input | 16 | Ring length configuration; bits 7:4 give log2 of the size |
| rx_valid | input | 1 | Frame byte present |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_data | input | 8 | Frame byte |
| rx_err_fram | input | 1 | Framing error, sampled with the last byte |
| rx_err_crc | input | 1 | CRC error, sampled with the last byte |
| rx_err_fifo | input | 1 | Buffer/FIFO error, sampled with the last byte |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| missed_cnt | output | MISS_W | Count of discarded frames, wraps around |

## Verification
A wrong ring index causes a frame to land in the wrong entry. This shows up on the very next frame, because the expected entry keeps its hand-off flag set and its old length. A stuck or missed hand-off state causes either a frame to be dropped when it should have been stored, or a returned entry to be overwritten. Both are visible in `missed_cnt` and in the entry's status four cycles after the last byte. A wrong byte counter corrupts the buffer contents or the length word, and this appears in the same frame's write-back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_WB_LEN_LO,
    ST_WB_LEN_HI,
    ST_WB_STAT,
    ST_WB_OWN
  } rx_state_e;

  // word offsets inside one ring entry
  localparam logic [2:0] OFS_BASE_LO = 3'd0;
  localparam logic [2:0] OFS_BASE_HI = 3'd1;
  localparam logic [2:0] OFS_BUFLEN  = 3'd2;
  localparam logic [2:0] OFS_STATUS  = 3'd3;
  localparam logic [2:0] OFS_MLEN_LO = 3'd4;
  localparam logic [2:0] OFS_MLEN_HI = 3'd5;

  // status word bit positions
  localparam int unsigned OWN_BIT  = 15;
  localparam int unsigned ERR_BIT  = 14;
  localparam int unsigned FRAM_BIT = 13;
  localparam int unsigned OVF_BIT  = 12;
  localparam int unsigned CRC_BIT  = 11;
  localparam int unsigned BUFE_BIT = 10;
  localparam int unsigned STP_BIT  = 9;
  localparam int unsigned ENP_BIT  = 8;

  localparam int unsigned MLEN_W = 12;

endpackage

// File: rtl/rxr_mem.sv
module rxr_mem #(
  parameter int unsigned AW  = 9,
  parameter int unsigned NRD = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     h_we,
  input  logic [AW-1:0]            h_addr,
  input  logic [15:0]              h_wdata,
  output logic [15:0]              h_rdata,
  input  logic                     c_we,
  input  logic [1:0]               c_be,
  input  logic [AW-1:0]            c_addr,
  input  logic [15:0]              c_wdata,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][15:0]     rd_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [15:0] mem_q [DEPTH];
  logic [15:0] h_rdata_q;

  // host write first, controller lanes override on the same word
  always_ff @(posedge clk) begin
    if (h_we) begin
      mem_q[h_addr] <= h_wdata;
    end
    for (int b = 0; b < 2; b++) begin
      if (c_we && c_be[b]) begin
        mem_q[c_addr][8*b +: 8] <= c_wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata_q <= '0;
    end else begin
      h_rdata_q <= mem_q[h_addr];
    end
  end

  assign h_rdata = h_rdata_q;

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem_q[rd_addr[g]];
  end

endmodule

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
  parameter int unsigned MAX_LOG = 3,
  localparam int unsigned IW     = (MAX_LOG > 0) ? MAX_LOG : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [3:0]    log_cfg,
  output logic [IW-1:0] idx
);

  logic [3:0]    log_eff;
  logic [IW-1:0] mask;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;

  always_comb begin
    log_eff = (log_cfg > 4'(MAX_LOG)) ? 4'(MAX_LOG) : log_cfg;
    mask    = '0;
    for (int b = 0; b < IW; b++) begin
      mask[b] = (int'(log_eff) > b);
    end
    idx_d = idx_q;
    if (adv) begin
      idx_d = (idx_q + 1'b1) & mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int unsigned AW     = 9,
  parameter int unsigned MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [7:0]        rx_data,
  input  logic              rx_err_fram,
  input  logic              rx_err_crc,
  input  logic              rx_err_fifo,
  input  logic [AW-1:0]     desc_waddr,
  input  logic [15:0]       rd_base_lo,
  input  logic [15:0]       rd_base_hi,
  input  logic [15:0]       rd_buflen,
  input  logic [15:0]       rd_status,
  output logic              c_we,
  output logic [1:0]        c_be,
  output logic [AW-1:0]     c_addr,
  output logic [15:0]       c_wdata,
  output logic              adv,
  output rx_state_e         st,
  output logic [MISS_W-1:0] missed_cnt
);

  localparam int unsigned BAW      = AW + 1;
  localparam logic [15:0] CNT_MAX  = '1;
  localparam logic [15:0] MLEN_MAX = 16'((1 << MLEN_W) - 1);

  rx_state_e         st_q, st_d;
  logic [31:0]       base_q, base_d;
  logic [15:0]       size_q, size_d;
  logic [15:0]       cnt_q, cnt_d;
  logic              fram_q, fram_d;
  logic              crc_q, crc_d;
  logic              fifo_q, fifo_d;
  logic              ovf_q, ovf_d;
  logic              early_q, early_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              lat_en;

  logic              idle;
  logic              owned;
  logic [31:0]       cur_base;
  logic [15:0]       cur_size;
  logic [15:0]       cur_cnt;
  logic              keep;
  logic [31:0]       byte_addr;
  logic [15:0]       stored;
  logic [15:0]       mlen;
  logic [6:0]        stat_hi;
  logic              unused_sink;

  always_comb begin
    idle      = (st_q == ST_IDLE);
    owned     = rd_status[OWN_BIT];
    cur_base  = idle ? {rd_base_hi, rd_base_lo} : base_q;
    cur_size  = idle ? (16'd0 - rd_buflen) : size_q;
    cur_cnt   = idle ? 16'd0 : cnt_q;
    keep      = (cur_cnt < cur_size);
    byte_addr = cur_base + {16'd0, cur_cnt};
    stored    = (cnt_q > size_q) ? size_q : cnt_q;
    mlen      = (stored > MLEN_MAX) ? MLEN_MAX : stored;
    stat_hi   = {(fram_q | ovf_q | crc_q | fifo_q), fram_q, ovf_q, crc_q, fifo_q, 2'b11};
  end

  assign unused_sink = ^{byte_addr[31:BAW], rd_status[14:8]};

  // next-state process
  always_comb begin
    st_d    = st_q;
    base_d  = base_q;
    size_d  = size_q;
    cnt_d   = cnt_q;
    fram_d  = fram_q;
    crc_d   = crc_q;
    fifo_d  = fifo_q;
    ovf_d   = ovf_q;
    early_d = early_q;
    miss_d  = miss_q;
    lat_en  = 1'b0;
    c_we    = 1'b0;
    c_be    = 2'b00;
    c_addr  = byte_addr[AW:1];
    c_wdata = {rx_data, rx_data};
    adv     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (rx_valid) begin
          if (owned) begin
            lat_en = 1'b1;
            base_d = cur_base;
            size_d = cur_size;
            cnt_d  = 16'd1;
            ovf_d  = !keep;
            c_we   = keep;
            c_be   = byte_addr[0] ? 2'b10 : 2'b01;
            st_d   = rx_last ? ST_WB_LEN_LO : ST_RECV;
          end else begin
            miss_d = miss_q + 1'b1;
            st_d   = rx_last ? ST_IDLE : ST_DROP;
          end
        end
      end
      ST_RECV: begin
        if (rx_valid) begin
          c_we  = keep;
          c_be  = byte_addr[0] ? 2'b10 : 2'b01;
          ovf_d = ovf_q | !keep;
          cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
          if (rx_last) begin
            lat_en = 1'b1;
            st_d   = ST_WB_LEN_LO;
          end
        end
      end
      ST_DROP: begin
        if (rx_valid && rx_last) begin
          st_d = ST_IDLE;
        end
      end
      ST_WB_LEN_LO: begin
        c_we    = 1'b1;
        c_be    = 2'b11;
        c_addr  = desc_waddr + AW'(OFS_MLEN_LO);
        c_wdata = mlen;
        st_d    = ST_WB_LEN_HI;
      end
      ST_WB_LEN_HI: begin
        c_we    = 1'b1;
        c_be    = 2'b11;
        c_addr  = desc_waddr + AW'(OFS_MLEN_HI);
        c_wdata = 16'd0;
        st_d    = ST_WB_STAT;
      end
      ST_WB_STAT: begin
        c_we    = 1'b1;
        c_be    = 2'b11;
        c_addr  = desc_waddr + AW'(OFS_STATUS);
        c_wdata = {1'b1, stat_hi, rd_status[7:0]};
        st_d    = ST_WB_OWN;
      end
      ST_WB_OWN: begin
        c_we    = 1'b1;
        c_be    = 2'b11;
        c_addr  = desc_waddr + AW'(OFS_STATUS);
        c_wdata = {1'b0, stat_hi, rd_status[7:0]};
        adv     = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    // a frame starting during write-back is discarded
    if (st_q inside {ST_WB_LEN_LO, ST_WB_LEN_HI, ST_WB_STAT, ST_WB_OWN}) begin
      if (rx_valid) begin
        if (!early_q) begin
          miss_d = miss_q + 1'b1;
        end
        early_d = !rx_last;
      end
      if (st_q == ST_WB_OWN) begin
        st_d    = early_d ? ST_DROP : ST_IDLE;
        early_d = 1'b0;
      end
    end

    if (lat_en && rx_last) begin
      fram_d = rx_err_fram;
      crc_d  = rx_err_crc;
      fifo_d = rx_err_fifo;
    end else if (lat_en) begin
      fram_d = 1'b0;
      crc_d  = 1'b0;
      fifo_d = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      size_q  <= '0;
      cnt_q   <= '0;
      fram_q  <= 1'b0;
      crc_q   <= 1'b0;
      fifo_q  <= 1'b0;
      ovf_q   <= 1'b0;
      early_q <= 1'b0;
      miss_q  <= '0;
    end else begin
      st_q    <= st_d;
      early_q <= early_d;
      miss_q  <= miss_d;
      if (rx_valid) begin
        base_q <= base_d;
        size_q <= size_d;
        cnt_q  <= cnt_d;
        ovf_q  <= ovf_d;
      end
      if (lat_en) begin
        fram_q <= fram_d;
        crc_q  <= crc_d;
        fifo_q <= fifo_d;
      end
    end
  end

  assign st         = st_q;
  assign missed_cnt = miss_q;

endmodule

// File: rtl/rxr_desc_writer.sv
module rxr_desc_writer
  import rxr_pkg::*;
#(
  parameter int unsigned AW      = 9,
  parameter int unsigned MAX_LOG = 3,
  parameter int unsigned MISS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW:0]       ring_base,
  input  logic [15:0]       ring_len_cfg,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [7:0]        rx_data,
  input  logic              rx_err_fram,
  input  logic              rx_err_crc,
  input  logic              rx_err_fifo,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic [MISS_W-1:0] missed_cnt
);

  localparam int unsigned IW  = (MAX_LOG > 0) ? MAX_LOG : 1;
  localparam int unsigned NRD = 4;

  logic [IW-1:0]           idx;
  logic                    adv;
  rx_state_e               st;
  logic [AW-1:0]           desc_w;
  logic [NRD-1:0][AW-1:0]  rd_addr;
  logic [NRD-1:0][15:0]    rd_data;
  logic                    c_we;
  logic [1:0]              c_be;
  logic [AW-1:0]           c_addr;
  logic [15:0]             c_wdata;
  logic                    unused_cfg;

  assign unused_cfg = ^{ring_base[3:0], ring_len_cfg[15:8], ring_len_cfg[3:0]};

  assign desc_w = {ring_base[AW:4], 3'b000} + (AW'(idx) << 3);

  for (genvar g = 0; g < NRD; g++) begin : g_rda
    assign rd_addr[g] = desc_w + AW'(g);
  end

  rxr_ring_idx #(.MAX_LOG(MAX_LOG)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .log_cfg (ring_len_cfg[7:4]),
    .idx     (idx)
  );

  rxr_mem #(.AW(AW), .NRD(NRD)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_we    (host_we),
    .h_addr  (host_addr),
    .h_wdata (host_wdata),
    .h_rdata (host_rdata),
    .c_we    (c_we),
    .c_be    (c_be),
    .c_addr  (c_addr),
    .c_wdata (c_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  rxr_ctrl #(.AW(AW), .MISS_W(MISS_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_last     (rx_last),
    .rx_data     (rx_data),
    .rx_err_fram (rx_err_fram),
    .rx_err_crc  (rx_err_crc),
    .rx_err_fifo (rx_err_fifo),
    .desc_waddr  (desc_w),
    .rd_base_lo  (rd_data[OFS_BASE_LO]),
    .rd_base_hi  (rd_data[OFS_BASE_HI]),
    .rd_buflen   (rd_data[OFS_BUFLEN]),
    .rd_status   (rd_data[OFS_STATUS]),
    .c_we        (c_we),
    .c_be        (c_be),
    .c_addr      (c_addr),
    .c_wdata     (c_wdata),
    .adv         (adv),
    .st          (st),
    .missed_cnt  (missed_cnt)
  );

endmodule

// File: rtl/rxr_desc_writer_chk.sv
module rxr_desc_writer_chk
  import rxr_pkg::*;
#(
  parameter int unsigned AW     = 9,
  parameter int unsigned IW     = 3,
  parameter int unsigned MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c_we,
  input logic [1:0]        c_be,
  input logic [AW-1:0]     c_addr,
  input logic [15:0]       c_wdata,
  input logic              adv,
  input logic [IW-1:0]     idx,
  input rx_state_e         st,
  input logic [MISS_W-1:0] missed_cnt
);

  // R9
  own_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_be == 2'b11 && c_addr[2:0] == OFS_STATUS && !c_wdata[OWN_BIT])
      |-> ($past(c_we) && $past(c_addr) == c_addr && $past(c_wdata[OWN_BIT])
           && $past(c_wdata[14:0]) == c_wdata[14:0]));

  // R9
  own_after_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_be == 2'b11 && c_addr[2:0] == OFS_STATUS && !c_wdata[OWN_BIT])
      |-> ($past(st, 2) == ST_WB_LEN_HI));

  // R3
  mlen_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_be == 2'b11 && c_addr[2:0] == OFS_MLEN_LO) |-> (c_wdata[15:12] == 4'd0));

  // R4
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_be == 2'b11 && c_addr[2:0] == OFS_STATUS && !c_wdata[OWN_BIT])
      |-> (c_wdata[STP_BIT] && c_wdata[ENP_BIT] && adv));

  // R8
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(missed_cnt) |-> (missed_cnt == $past(missed_cnt) + 1'b1));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx) |-> $past(adv));

  // R2
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_be != 2'b11) |-> ($countones(c_be) == 1));

endmodule

bind rxr_desc_writer rxr_desc_writer_chk #(
  .AW(AW), .IW(IW), .MISS_W(MISS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .c_we       (c_we),
  .c_be       (c_be),
  .c_addr     (c_addr),
  .c_wdata    (c_wdata),
  .adv        (adv),
  .idx        (idx),
  .st         (st),
  .missed_cnt (missed_cnt)
);

// File: tb/tb_rxr_desc_writer.sv
module tb_rxr_desc_writer;

  localparam int AW      = 9;
  localparam int MAX_LOG = 3;
  localparam int MISS_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [AW:0]       ring_base;
  logic [15:0]       ring_len_cfg;
  logic              rx_valid, rx_last;
  logic [7:0]        rx_data;
  logic              rx_err_fram, rx_err_crc, rx_err_fifo;
  logic              host_we;
  logic [AW-1:0]     host_addr;
  logic [15:0]       host_wdata;
  logic [15:0]       host_rdata;
  logic [MISS_W-1:0] missed_cnt;

  always #2 clk = ~clk;

  rxr_desc_writer #(.AW(AW), .MAX_LOG(MAX_LOG), .MISS_W(MISS_W)) dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] frm [256];
  int nxt_idx = 0;
  int ring_n  = 4;
  int exp_miss = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_wdata = 16'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input int a, output int d);
    @(negedge clk);
    host_we = 1'b0; host_addr = AW'(a);
    @(negedge clk);
    d = int'(host_rdata);
  endtask

  function automatic int buf_byte(input int i);
    return 128 + i * 64;
  endfunction

  function automatic int exp_status(input int tag, input bit fr, input bit ov,
                                    input bit cr, input bit ff);
    int s;
    s = (tag & 8'hFF) | 16'h0300;
    if (fr) s |= 16'h2000;
    if (ov) s |= 16'h1000;
    if (cr) s |= 16'h0800;
    if (ff) s |= 16'h0400;
    if (fr || ov || cr || ff) s |= 16'h4000;
    return s;
  endfunction

  task automatic prep(input int i, input int bs, input bit own, input int tag);
    int b;
    b = buf_byte(i);
    hw(i*8 + 0, b & 16'hFFFF);
    hw(i*8 + 1, 0);
    hw(i*8 + 2, (-bs) & 16'hFFFF);
    hw(i*8 + 4, 16'hBEEF);
    hw(i*8 + 5, 16'hBEEF);
    for (int w = 0; w < 32; w++) hw(b/2 + w, 16'hA5A5);
    hw(i*8 + 3, (own ? 16'h8000 : 0) | (tag & 8'hFF));
  endtask

  task automatic send(input int len, input bit fr, input bit cr, input bit ff, input bit tail);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = frm[k]; rx_last = (k == len-1);
      rx_err_fram = (k == len-1) ? fr : 1'b0;
      rx_err_crc  = (k == len-1) ? cr : 1'b0;
      rx_err_fifo = (k == len-1) ? ff : 1'b0;
    end
    if (tail) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
      rx_err_fram = 1'b0; rx_err_crc = 1'b0; rx_err_fifo = 1'b0;
    end
  endtask

  task automatic fill_rand(input int len);
    for (int k = 0; k < len; k++) frm[k] = 8'($urandom);
  endtask

  task automatic check_entry(input int i, input int bs, input int len, input bit fr,
                             input bit cr, input bit ff, input int tag, input string req);
    int stored, es, v, bad, b, eb;
    bit ov;
    repeat (8) @(negedge clk);
    ov = (len > bs);
    stored = ov ? bs : len;
    es = exp_status(tag, fr, ov, cr, ff);
    hr(i*8 + 3, v);
    chk(v == es, {req, " status (R4/R5)"}, v, es);
    hr(i*8 + 4, v);
    chk(v == stored, {req, " length R3"}, v, stored);
    hr(i*8 + 5, v);
    chk(v == 0, {req, " length high R3"}, v, 0);
    bad = 0;
    b = buf_byte(i);
    for (int w = 0; w < 32; w++) begin
      hr(b/2 + w, v);
      for (int h = 0; h < 2; h++) begin
        eb = (2*w + h < stored) ? int'(frm[2*w + h]) : 8'hA5;
        if (((v >> (8*h)) & 8'hFF) != eb) bad++;
      end
    end
    chk(bad == 0, ov ? {req, " truncated buffer R6"} : {req, " buffer R2"}, bad, 0);
    chk(int'(missed_cnt) == exp_miss, {req, " missed count R8"}, int'(missed_cnt), exp_miss);
  endtask

  task automatic do_frame(input int len, input int bs, input bit fr, input bit cr,
                          input bit ff, input string req);
    int tag;
    tag = int'($urandom) & 8'hFF;
    fill_rand(len);
    prep(nxt_idx, bs, 1'b1, tag);
    send(len, fr, cr, ff, 1'b1);
    check_entry(nxt_idx, bs, len, fr, cr, ff, tag, req);
    nxt_idx = (nxt_idx + 1) % ring_n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int v, tag, i0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; ring_base = '0; ring_len_cfg = 16'h0020;
    rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    rx_err_fram = 1'b0; rx_err_crc = 1'b0; rx_err_fifo = 1'b0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(missed_cnt == 0, "R1 missed after reset", int'(missed_cnt), 0);
    chk(host_rdata == 0, "R1 rdata after reset", int'(host_rdata), 0);

    // R11 host port
    hw(500, 16'h1234);
    hr(500, v);
    chk(v == 16'h1234, "R11 host readback", v, 16'h1234);

    // R1/R2/R4: first frame lands in entry 0, length equal to buffer size
    do_frame(60, 60, 0, 0, 0, "R1 entry0 full buffer");
    do_frame(1, 60, 0, 0, 0, "R2 single byte");
    do_frame(45, 20, 0, 0, 0, "R6 overlong");
    do_frame(12, 60, 1, 0, 0, "R5 framing");
    do_frame(13, 60, 0, 1, 0, "R5 crc");
    do_frame(14, 60, 0, 0, 1, "R5 fifo");

    // R7 random traffic wrapping the 4-entry ring
    for (int n = 0; n < 10; n++) begin
      do_frame(1 + int'($urandom % 60), 60 - int'($urandom % 8),
               ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0, "R7 random");
    end

    // R8 entry held by host: frame discarded, index unchanged
    tag = 8'h5C;
    fill_rand(10);
    prep(nxt_idx, 60, 1'b0, tag);
    send(10, 0, 0, 0, 1'b1);
    exp_miss++;
    repeat (8) @(negedge clk);
    chk(int'(missed_cnt) == exp_miss, "R8 missed count", int'(missed_cnt), exp_miss);
    hr(nxt_idx*8 + 3, v);
    chk(v == tag, "R8 status untouched", v, tag);
    hr(buf_byte(nxt_idx)/2, v);
    chk(v == 16'hA5A5, "R8 buffer untouched", v, 16'hA5A5);
    do_frame(20, 60, 0, 0, 0, "R8 same entry after return");

    // R10 frame starting inside write-back is discarded
    i0 = nxt_idx;
    tag = 8'h33;
    prep((i0 + 1) % ring_n, 60, 1'b1, tag);
    fill_rand(8);
    prep(i0, 60, 1'b1, 8'h11);
    send(8, 0, 0, 0, 1'b0);
    send(8, 0, 0, 0, 1'b1);
    exp_miss++;
    check_entry(i0, 60, 8, 0, 0, 0, 8'h11, "R10 first frame");
    hr(((i0 + 1) % ring_n)*8 + 3, v);
    chk(v == (16'h8000 | tag), "R10 next entry untouched", v, 16'h8000 | tag);
    nxt_idx = (nxt_idx + 1) % ring_n;
    do_frame(30, 60, 0, 0, 0, "R10 after discard");

    // R7 clamp: size field 15 limited to 8 entries, other bits ignored
    while (nxt_idx != 0) do_frame(5, 60, 0, 0, 0, "R7 align");
    ring_len_cfg = 16'h3CF5;
    ring_n = 8;
    for (int n = 0; n < 9; n++) begin
      do_frame(2 + int'($urandom % 50), 60, 0, ($urandom % 4) == 0, 0, "R7 clamp ring");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule